// File: doc/BRIEF.md
# Compressing Execution Trace Buffer

This block keeps a short history of where program flow stopped running in a straight line. Each time the core takes a branch, jump, call, return or event entry, it presents the address it left and the address it went to. The block stores that pair as one entry in a small first-in first-out store. A debugger later drains the store from its read port, oldest entry first.

Tight software loops would flood such a store with identical backward branches. To avoid this, the block can fold a repeated discontinuity into an existing entry: it adds one to that entry's repeat counter and does not take a new slot. A two-bit setting selects how far back the block looks. With the first setting it compares against the newest entry only, which covers one loop. With the second it also compares against the entry before that, which covers an inner loop nested inside an outer one. When the store is full and a new pair arrives, the oldest entry is lost and a sticky flag records the loss.

The discontinuity input is a valid/ready stream, but the block never applies back-pressure on it: `disc_ready` is always high, so every strobe is taken in the cycle it is presented. The read side is also a valid/ready stream. `rd_valid` is high whenever at least one entry is held, and an entry is removed in a cycle where both `rd_valid` and `rd_ready` are high. While the reader stalls, the presented source and target stay unchanged. There is one exception: an overflow drop in that same cycle discards the presented entry. The presented repeat count may also rise while the reader stalls, if that entry is still being folded into.

Top module: `trc_buffer`

## Requirements
- R1: After reset the store is empty: `rd_valid` is 0, `rd_empty` is 1 and `ovf_flag` is 0.
- R2: `disc_ready` is always 1. When folding is off, every accepted discontinuity becomes a new entry with a repeat count of 0. Entries leave in arrival order.
- R3: An entry is removed only in a cycle where both `rd_valid` and `rd_ready` are high. While `rd_valid` is high and `rd_ready` is low, `rd_src` and `rd_dst` hold their values unless an overflow drop occurs in that cycle. `rd_ready` while the store is empty has no effect.
- R4: With `cmp_level` = 1, a discontinuity whose source and target both equal those of the newest held entry adds one to that entry's count. No new entry is created.
- R5: The repeat count is 8 bits wide and saturates at 255. Further matches leave it at 255.
- R6: With `cmp_level` = 2 or 3, the newest entry is compared first and then the second newest. The first one that matches has its count raised. If neither matches, a new entry is created.
- R7: With `cmp_level` = 1, a discontinuity that matches only the second newest entry creates a new entry.
- R8: When 16 entries are held, no entry is read in that cycle, and a non-matching discontinuity arrives, the oldest entry is discarded and the new one appended. `ovf_flag` then goes to 1 and stays 1 until reset.
- R9: When a read and a discontinuity happen in the same cycle, the comparison uses only the entries that remain after the read.
- R10: `cmp_level` encoding: 0 means folding off, 1 means one level, 2 and 3 both mean two levels.
- R11: `cmp_level` is sampled per discontinuity. Changing it affects only discontinuities presented afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_valid | input | 1 | A discontinuity is presented |
| disc_ready | output | 1 | Always 1; the block accepts every discontinuity |
| disc_src | input | 32 | Address the flow left |
| disc_dst | input | 32 | Address the flow went to |
| cmp_level | input | 2 | Folding depth: 0 off, 1 one level, 2 or 3 two levels |
| rd_valid | output | 1 | The oldest entry is presented |
| rd_ready | input | 1 | Reader takes the presented entry |
| rd_src | output | 32 | Source address of the oldest entry (0 when empty) |
| rd_dst | output | 32 | Target address of the oldest entry (0 when empty) |
| rd_reps | output | 8 | Repeat count of the oldest entry (0 when empty) |
| rd_empty | output | 1 | No entry is held |
| ovf_flag | output | 1 | Sticky: at least one entry was lost to overwrite |

## Verification
The assertions rely on `rst_n` being held for at least one clock edge before checks apply. They also rely on `disc_valid`, the addresses, `cmp_level` and `rd_ready` being steady around each rising edge. The hold rule on the read side additionally takes for granted that an overflow drop is the only way the oldest entry can leave without a read. The bench changes every input only on falling edges and holds the reset low for three cycles. Its random phase draws addresses from a small pool of three pairs, so that matches, nested matches, overflow and concurrent reads all occur often.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [CNT_W-1:0]  reps;
  } trc_entry_t;

  // folding window size selected by the two-bit level setting
  function automatic int unsigned lvl_window(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 0;
      2'd1:    return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/trc_store.sv
module trc_store
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL   = 2,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic              drop_i,
  input  logic [ADDR_W-1:0] push_src_i,
  input  logic [ADDR_W-1:0] push_dst_i,
  input  logic              bump_i,
  input  logic [PTR_W-1:0]  bump_idx_i,
  output trc_entry_t        head_o,
  output logic [OCC_W-1:0]  occ_o,
  output trc_entry_t        near_o     [LVL],
  output logic [PTR_W-1:0]  near_idx_o [LVL]
);
  trc_entry_t       ent_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [OCC_W-1:0] occ_q;

  function automatic logic [PTR_W-1:0] step_fwd(input logic [PTR_W-1:0] p);
    if (int'(p) == int'(DEPTH) - 1) return '0;
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] step_back(input logic [PTR_W-1:0] p,
                                                 input int unsigned k);
    int t;
    t = int'(p) - int'(k);
    if (t < 0) t = t + int'(DEPTH);
    return PTR_W'(t);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push_i) begin
        ent_q[tail_q].src  <= push_src_i;
        ent_q[tail_q].dst  <= push_dst_i;
        ent_q[tail_q].reps <= '0;
      end
      if (bump_i && (ent_q[bump_idx_i].reps != '1))
        ent_q[bump_idx_i].reps <= ent_q[bump_idx_i].reps + CNT_W'(1);
      if (pop_i || drop_i) head_q <= step_fwd(head_q);
      if (push_i)          tail_q <= step_fwd(tail_q);
      occ_q <= occ_q + OCC_W'(push_i) - OCC_W'(pop_i) - OCC_W'(drop_i);
    end
  end

  assign head_o = ent_q[head_q];
  assign occ_o  = occ_q;

  // newest entries, index 0 is the most recent
  for (genvar g = 0; g < LVL; g++) begin : g_near
    assign near_idx_o[g] = step_back(tail_q, g + 1);
    assign near_o[g]     = ent_q[near_idx_o[g]];
  end

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  // R8
  drop_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |-> (occ_q == OCC_W'(DEPTH)) && !pop_i && push_i);

  // R4
  bump_push_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bump_i && push_i));

  // R4
  bump_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump_i && (ent_q[bump_idx_i].reps != '1)
    |=> ent_q[$past(bump_idx_i)].reps == $past(ent_q[bump_idx_i].reps) + CNT_W'(1));

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump_i && (ent_q[bump_idx_i].reps == '1)
    |=> ent_q[$past(bump_idx_i)].reps == '1);
endmodule

// File: rtl/trc_match.sv
module trc_match
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL   = 2,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1),
  localparam int unsigned SEL_W = (LVL > 1) ? $clog2(LVL) : 1
) (
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [1:0]        lvl_i,
  input  logic [OCC_W-1:0]  avail_i,
  input  trc_entry_t        near_i [LVL],
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  int unsigned win;
  logic [LVL-1:0] cand;

  always_comb begin
    win = lvl_window(lvl_i);
    if (win > LVL) win = LVL;
  end

  for (genvar g = 0; g < LVL; g++) begin : g_cmp
    assign cand[g] = (g < win) && (OCC_W'(g) < avail_i)
                     && (near_i[g].src == src_i) && (near_i[g].dst == dst_i);
  end

  // lowest index (newest entry) wins
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int i = LVL - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_o = 1'b1;
        sel_o = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/trc_buffer.sv
module trc_buffer
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL   = 2,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned OCC_W = $clog2(DEPTH + 1),
  localparam int unsigned SEL_W = (LVL > 1) ? $clog2(LVL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disc_valid,
  output logic              disc_ready,
  input  logic [ADDR_W-1:0] disc_src,
  input  logic [ADDR_W-1:0] disc_dst,
  input  logic [1:0]        cmp_level,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [CNT_W-1:0]  rd_reps,
  output logic              rd_empty,
  output logic              ovf_flag
);
  trc_entry_t       head;
  logic [OCC_W-1:0] occ, avail;
  trc_entry_t       near     [LVL];
  logic [PTR_W-1:0] near_idx [LVL];
  logic             pop, in_fire, hit, bump, push, drop, ovf_q;
  logic [SEL_W-1:0] hit_sel;

  assign disc_ready = 1'b1;
  assign rd_valid   = (occ != '0);
  assign rd_empty   = ~rd_valid;
  assign pop        = rd_valid & rd_ready;
  assign avail      = occ - OCC_W'(pop);
  assign in_fire    = disc_valid & disc_ready;
  assign bump       = in_fire & hit;
  assign push       = in_fire & ~hit;
  assign drop       = push & (avail == OCC_W'(DEPTH));

  trc_store #(.DEPTH(DEPTH), .LVL(LVL)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_i      (pop),
    .push_i     (push),
    .drop_i     (drop),
    .push_src_i (disc_src),
    .push_dst_i (disc_dst),
    .bump_i     (bump),
    .bump_idx_i (near_idx[hit_sel]),
    .head_o     (head),
    .occ_o      (occ),
    .near_o     (near),
    .near_idx_o (near_idx)
  );

  trc_match #(.DEPTH(DEPTH), .LVL(LVL)) u_match (
    .src_i   (disc_src),
    .dst_i   (disc_dst),
    .lvl_i   (cmp_level),
    .avail_i (avail),
    .near_i  (near),
    .hit_o   (hit),
    .sel_o   (hit_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  assign ovf_flag = ovf_q;
  assign rd_src   = rd_valid ? head.src  : '0;
  assign rd_dst   = rd_valid ? head.dst  : '0;
  assign rd_reps  = rd_valid ? head.reps : '0;

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R8
  full_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disc_valid && !hit && !rd_ready && (occ == OCC_W'(DEPTH)) |=> ovf_flag);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !drop |=> rd_valid && $stable(rd_src) && $stable(rd_dst));

  // R3
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && !disc_valid |=> !rd_valid);

  // R2
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !drop |=> occ == $past(occ) + OCC_W'(1));

  // R4
  bump_keeps_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump && !pop |=> occ == $past(occ));

  // R10
  off_no_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disc_valid && (cmp_level == 2'd0) |-> !hit);

  // R7
  one_lvl_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (cmp_level == 2'd1) |-> hit_sel == '0);
endmodule

// File: tb/sim_trc_buffer.sv
module sim_trc_buffer;
  import trc_pkg::*;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        disc_valid, disc_ready, rd_valid, rd_ready, rd_empty, ovf_flag;
  logic [31:0] disc_src, disc_dst, rd_src, rd_dst;
  logic [1:0]  cmp_level;
  logic [7:0]  rd_reps;

  always #5 clk = ~clk;

  trc_buffer #(.DEPTH(DEPTH), .LVL(2)) u0 (
    .clk(clk), .rst_n(rst_n), .disc_valid(disc_valid), .disc_ready(disc_ready),
    .disc_src(disc_src), .disc_dst(disc_dst), .cmp_level(cmp_level),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_src(rd_src), .rd_dst(rd_dst),
    .rd_reps(rd_reps), .rd_empty(rd_empty), .ovf_flag(ovf_flag)
  );

  typedef struct { logic [31:0] s; logic [31:0] d; int r; } ment_t;
  ment_t mq[$];
  bit    m_ovf;
  int    checks, fails;
  string cur;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", cur, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("rd_valid", 64'(rd_valid), 64'(mq.size() > 0));
    chk("rd_empty", 64'(rd_empty), 64'(mq.size() == 0));
    chk("ovf_flag", 64'(ovf_flag), 64'(m_ovf));
    chk("disc_ready", 64'(disc_ready), 64'd1);
    if (mq.size() > 0) begin
      chk("rd_src", 64'(rd_src), 64'(mq[0].s));
      chk("rd_dst", 64'(rd_dst), 64'(mq[0].d));
      chk("rd_reps", 64'(rd_reps), 64'(mq[0].r));
    end
  endtask

  task automatic model_step(input bit v, input logic [31:0] s, input logic [31:0] d,
                            input logic [1:0] lvl, input bit rdy);
    int n, hit, win;
    ment_t e;
    if (rdy && mq.size() > 0) void'(mq.pop_front());
    if (v) begin
      n   = mq.size();
      hit = -1;
      win = (lvl == 2'd0) ? 0 : (lvl == 2'd1) ? 1 : 2;
      for (int k = 0; k < win; k++)
        if (hit < 0 && k < n && mq[n-1-k].s == s && mq[n-1-k].d == d) hit = n - 1 - k;
      if (hit >= 0) begin
        e = mq[hit];
        if (e.r < 255) e.r++;
        mq[hit] = e;
      end else begin
        if (n == DEPTH) begin
          void'(mq.pop_front());
          m_ovf = 1'b1;
        end
        e.s = s; e.d = d; e.r = 0;
        mq.push_back(e);
      end
    end
  endtask

  // called just after a falling edge
  task automatic cyc(input bit v, input logic [31:0] s, input logic [31:0] d,
                     input logic [1:0] lvl, input bit rdy);
    disc_valid = v; disc_src = s; disc_dst = d; cmp_level = lvl; rd_ready = rdy;
    @(posedge clk);
    model_step(v, s, d, lvl, rdy);
    @(negedge clk);
    compare();
  endtask

  task automatic put(input logic [31:0] s, input logic [31:0] d, input logic [1:0] lvl);
    cyc(1'b1, s, d, lvl, 1'b0);
  endtask

  task automatic drain();
    while (mq.size() > 0) cyc(1'b0, '0, '0, 2'd0, 1'b1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=expired exp=run_complete");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; disc_valid = 1'b0; disc_src = '0; disc_dst = '0;
    cmp_level = 2'd0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur = "R1";
    compare();
    chk("reset rd_valid", 64'(rd_valid), 64'd0);

    // folding off: duplicates still create entries
    cur = "R2";
    put(32'h100, 32'h200, 2'd0);
    put(32'h100, 32'h200, 2'd0);
    put(32'h300, 32'h040, 2'd0);
    cur = "R10";
    put(32'h300, 32'h040, 2'd0);
    // stall, then read out; then read on empty
    cur = "R3";
    repeat (3) cyc(1'b0, '0, '0, 2'd0, 1'b0);
    drain();
    repeat (2) cyc(1'b0, '0, '0, 2'd0, 1'b1);

    // one level: fold on newest only
    cur = "R4";
    put(32'hA0, 32'hA4, 2'd1);
    put(32'hA0, 32'hA4, 2'd1);
    put(32'hA0, 32'hA4, 2'd1);
    chk("R4 reps after two folds", 64'(rd_reps), 64'd2);
    cur = "R7";
    put(32'hB0, 32'hB8, 2'd1);
    put(32'hA0, 32'hA4, 2'd1);
    drain();

    // two levels: inner and outer loop
    cur = "R6";
    put(32'hA0, 32'hA4, 2'd2);
    put(32'hB0, 32'hB8, 2'd2);
    put(32'hA0, 32'hA4, 2'd2);
    put(32'hB0, 32'hB8, 2'd2);
    put(32'hB0, 32'hB8, 2'd2);
    put(32'hC0, 32'hC8, 2'd2);
    cur = "R10";
    put(32'hB0, 32'hB8, 2'd3);
    put(32'hA0, 32'hA4, 2'd3);
    drain();

    // saturation
    cur = "R5";
    for (int i = 0; i < 300; i++) put(32'h55, 32'h66, 2'd1);
    chk("R5 reps saturated", 64'(rd_reps), 64'd255);
    drain();

    // overflow by overwrite
    cur = "R8";
    for (int i = 0; i < 20; i++) put(32'(i) * 32'h10, 32'(i) + 32'h9000, 2'd0);
    chk("R8 ovf set", 64'(ovf_flag), 64'd1);
    drain();
    chk("R8 ovf sticky", 64'(ovf_flag), 64'd1);

    // read and strobe in the same cycle
    cur = "R9";
    put(32'hD0, 32'hD4, 2'd1);
    cyc(1'b1, 32'hD0, 32'hD4, 2'd1, 1'b1);
    chk("R9 fresh entry reps", 64'(rd_reps), 64'd0);
    put(32'hE0, 32'hE4, 2'd2);
    cyc(1'b1, 32'hD0, 32'hD4, 2'd2, 1'b1);
    drain();

    // level change between strobes
    cur = "R11";
    put(32'hF0, 32'hF4, 2'd0);
    put(32'hF0, 32'hF4, 2'd1);
    put(32'hF0, 32'hF4, 2'd0);
    drain();

    // random mix over a small address pool
    cur = "R6";
    for (int i = 0; i < 3000; i++) begin
      int p;
      p = $urandom_range(0, 2);
      cyc(($urandom_range(0, 9) < 8), 32'h1000 + 32'(p), 32'h2000 + 32'(p),
          2'($urandom_range(0, 3)), ($urandom_range(0, 9) < 3));
    end
    drain();

    summary();
    $finish;
  end
endmodule